// File: doc/BRIEF.md
# Four-Bit Shared-Bus Processor

This block is a small 4-bit processor. Every data transfer goes over one shared main bus. Three units can drive the bus:

- the immediate nibble of the instruction word now executing,
- the output of an add/subtract unit working on two operand registers,
- the RAM word selected by an address register.

Each source has its own output enable. An instruction flips one of these enables; it never sets or clears it outright. The program must therefore open exactly the sources it wants. If more than one source is open, the bus carries the bitwise OR of all open sources and a conflict output is raised.

The processor works on a two-phase rhythm. On a fetch clock it reads the program word at the program counter and advances the counter. On the following execute clock it carries out that word. A program word is 8 bits: the upper nibble is an immediate value and the lower nibble is the command. An immediate reaches the bus only while the ROM source is open. For that reason a constant is always supplied in the same word as the command that consumes it.

For test purposes:

- A write port fills the program ROM.
- A halt input freezes the machine.
- A combinational peek port reads any RAM word.

Top module: `nibble_cpu`

## Requirements
- R1: A program word is 8 bits, immediate in bits 7:4 and command in bits 3:0. The command codes are:

  | Code | Action |
  |---|---|
  | 0 | Load address register from bus |
  | 1 | Load B from bus |
  | 2 | Load C from bus |
  | 3 | Load PC from bus |
  | 4 | Write bus into RAM at the address register |
  | 5 | Flip ALU output enable |
  | 6 | Flip ROM output enable |
  | 7 | Flip RAM output enable |
  | 8 | Flip add/subtract mode |
  | 9 | Load PC from bus if B equals C |
  | 10–15 | No operation |

- R2: The machine alternates fetch and execute clocks. A fetch latches ROM[PC] and increments PC by one, wrapping modulo 16. An execute that is not a PC load leaves PC unchanged. Running k words from reset leaves PC at k.
- R3: While the ROM source is open, the bus carries the immediate of the word being executed. While it is closed, the immediate has no effect on the bus.
- R4: With no source open the bus reads 0 and the conflict output is 0. With two or more sources open the bus is their bitwise OR and the conflict output is 1.
- R5: The ALU output is B+C in add mode and B−C in subtract mode, both modulo 16. Add mode is selected out of reset.
- R6: RAM writes and RAM bus reads both use the location held in the address register. The address register can be loaded from RAM data on the bus.
- R7: Command 3 always reloads PC from the bus. Command 9 reloads PC only when B equals C, and otherwise lets execution fall through.
- R8: While halt is high, PC, phase, registers, enables and RAM all hold, and no strobe acts. Releasing halt resumes the program exactly where it stopped.
- R9: Reset clears PC, phase, registers, enables, add/subtract mode and RAM. The bus then reads 0.
- R10: The following program leaves 4 in RAM word 0: open ROM; load B with 2; load C with 2; load address 0; close ROM; open ALU; write RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes all state while high |
| prog_we | input | 1 | Program ROM write strobe |
| prog_addr | input | 4 | Program ROM write address |
| prog_data | input | 8 | Program word to write |
| peek_addr | input | 4 | RAM read-back address |
| peek_data | output | 4 | RAM word at peek_addr |
| pc_o | output | 4 | Program counter |
| bus_o | output | 4 | Main bus value |
| conflict_o | output | 1 | Two or more bus sources open |

## Verification
The bench targets the one-word latency of the ROM source. A design that put the immediate on the bus in the same word that opens ROM would load the wrong constants, and every arithmetic row would store garbage.

It closes ROM and then writes RAM, so a design that leaked the immediate onto a closed bus would leave a non-zero word behind. It also leaves both ALU and ROM open. A design that prioritised one source instead of ORing them, or never raised the flag, would store the wrong word.

The conditional branch is run both taken and not taken, and the machine is halted mid-program and resumed. A design that branched unconditionally, or let halt slip a phase, would land on the wrong word.

// File: rtl/nibble_cpu.sv
module nibble_cpu #(
  parameter int DW = 4,
  parameter int PW = 4,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          prog_we,
  input  logic [PW-1:0] prog_addr,
  input  logic [DW+3:0] prog_data,
  input  logic [MW-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  output logic [PW-1:0] pc_o,
  output logic [DW-1:0] bus_o,
  output logic          conflict_o
);
  localparam int IW    = DW + 4;
  localparam int ROM_N = 1 << PW;
  localparam int RAM_N = 1 << MW;

  localparam logic [3:0] OP_LDA = 4'd0, OP_LDB = 4'd1, OP_LDC = 4'd2, OP_LDPC = 4'd3,
                         OP_WRM = 4'd4, OP_TALU = 4'd5, OP_TROM = 4'd6, OP_TRAM = 4'd7,
                         OP_TSUB = 4'd8, OP_JEQ = 4'd9;

  logic [IW-1:0] rom [ROM_N];
  logic [DW-1:0] ram [RAM_N];

  logic [PW-1:0] pc_q;
  logic          ph_q;
  logic [IW-1:0] ir_q;
  logic [MW-1:0] a_q;
  logic [DW-1:0] b_q, c_q;
  logic          sub_q, rom_en_q, alu_en_q, ram_en_q;

  logic [DW-1:0] imm, alu, ram_rd, bus;
  logic [3:0]    cmd;
  logic          exec;

  assign imm    = ir_q[IW-1:4];
  assign cmd    = ir_q[3:0];
  assign alu    = sub_q ? b_q - c_q : b_q + c_q;
  assign ram_rd = ram[a_q];
  assign bus    = ({DW{rom_en_q}} & imm) | ({DW{alu_en_q}} & alu) | ({DW{ram_en_q}} & ram_rd);
  assign exec   = ph_q & ~halt;

  assign bus_o      = bus;
  assign pc_o       = pc_q;
  assign peek_data  = ram[peek_addr];
  assign conflict_o = (rom_en_q & alu_en_q) | (rom_en_q & ram_en_q) | (alu_en_q & ram_en_q);

  always_ff @(posedge clk) begin
    if (prog_we) rom[prog_addr] <= prog_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_N; i++) ram[i] <= '0;
    end else if (exec && cmd == OP_WRM) begin
      ram[a_q] <= bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ph_q     <= 1'b0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      sub_q    <= 1'b0;
      rom_en_q <= 1'b0;
      alu_en_q <= 1'b0;
      ram_en_q <= 1'b0;
    end else if (!halt) begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        ir_q <= rom[pc_q];
        pc_q <= pc_q + 1'b1;
      end else begin
        case (cmd)
          OP_LDA:  a_q      <= MW'(bus);
          OP_LDB:  b_q      <= bus;
          OP_LDC:  c_q      <= bus;
          OP_LDPC: pc_q     <= PW'(bus);
          OP_TALU: alu_en_q <= ~alu_en_q;
          OP_TROM: rom_en_q <= ~rom_en_q;
          OP_TRAM: ram_en_q <= ~ram_en_q;
          OP_TSUB: sub_q    <= ~sub_q;
          OP_JEQ:  if (b_q == c_q) pc_q <= PW'(bus);
          default: ;
        endcase
      end
    end
  end
endmodule

module nibble_cpu_chk #(
  parameter int DW = 4,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halt,
  input logic [PW-1:0] pc,
  input logic          ph,
  input logic [DW+3:0] ir,
  input logic          en_rom,
  input logic          en_alu,
  input logic          en_ram,
  input logic [DW-1:0] bus,
  input logic          conflict
);
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(pc) && $stable(ph)));
  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !ph) |=> (pc == PW'($past(pc) + 1'b1)));
  // R2
  exec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && ph && ir[3:0] != 4'd3 && ir[3:0] != 4'd9) |=> $stable(pc));
  // R2
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> (ph != $past(ph)));
  // R4
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({en_rom, en_alu, en_ram} == 3'b000) |-> (bus == '0 && !conflict));
  // R4
  single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conflict |-> $onehot0({en_rom, en_alu, en_ram}));
  // R3
  rom_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rom && !en_alu && !en_ram) |-> (bus == ir[DW+3:4]));
endmodule

bind nibble_cpu nibble_cpu_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .pc(pc_q), .ph(ph_q), .ir(ir_q),
  .en_rom(rom_en_q), .en_alu(alu_en_q), .en_ram(ram_en_q),
  .bus(bus_o), .conflict(conflict_o)
);

// File: tb/sim_nibble_cpu.sv
module sim_nibble_cpu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 1'b1;
  logic       prog_we = 1'b0;
  logic [3:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic [3:0] peek_addr = '0;
  logic [3:0] peek_data, pc_o, bus_o;
  logic       conflict_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] prog [16];

  // {a, b, sub, addr, expected}
  localparam logic [16:0] VEC [6] = '{
    {4'd2,  4'd2, 1'b0, 4'd0, 4'd4},
    {4'd9,  4'd9, 1'b0, 4'd1, 4'd2},
    {4'd7,  4'd3, 1'b1, 4'd2, 4'd4},
    {4'd3,  4'd5, 1'b1, 4'd3, 4'd14},
    {4'd15, 4'd1, 1'b0, 4'd4, 4'd0},
    {4'd0,  4'd0, 1'b1, 4'd5, 4'd0}
  };

  nibble_cpu u0 (
    .clk(clk), .rst_n(rst_n), .halt(halt), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .pc_o(pc_o), .bus_o(bus_o), .conflict_o(conflict_o)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] w(input logic [3:0] v, input logic [3:0] c);
    return {v, c};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 8'h0F;
  endtask

  task automatic start();
    @(negedge clk);
    halt = 1'b1;
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) begin
      prog_we = 1'b1; prog_addr = 4'(i); prog_data = prog[i];
      @(negedge clk);
    end
    prog_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic go(input int words);
    halt = 1'b0;
    repeat (2 * words) @(negedge clk);
    halt = 1'b1;
    #1;
  endtask

  task automatic peek(input logic [3:0] a, input int exp, input string req);
    peek_addr = a;
    #1;
    chk(req, peek_data, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    clear_prog();
    start();
    chk("R9 pc", pc_o, 0);
    chk("R9 bus idle", bus_o, 0);
    chk("R4 no conflict", conflict_o, 0);
    peek(4'd0, 0, "R9 ram clear");

    // R10 stated program, halted mid-way (R8)
    clear_prog();
    prog[0] = w(0, 6); prog[1] = w(2, 1); prog[2] = w(2, 2); prog[3] = w(0, 0);
    prog[4] = w(0, 6); prog[5] = w(0, 5); prog[6] = w(0, 4);
    start();
    go(3);
    chk("R2 pc after 3", pc_o, 3);
    repeat (20) @(negedge clk);
    chk("R8 pc frozen", pc_o, 3);
    go(4);
    peek(4'd0, 4, "R10 2+2");
    chk("R2 pc after 7", pc_o, 7);

    // R5 R6 R1 arithmetic vectors
    for (int k = 0; k < 6; k++) begin
      clear_prog();
      prog[0] = w(0, 6);
      prog[1] = w(VEC[k][16:13], 1);
      prog[2] = w(VEC[k][12:9], 2);
      prog[3] = w(VEC[k][7:4], 0);
      prog[4] = w(0, VEC[k][8] ? 4'd8 : 4'd15);
      prog[5] = w(0, 6); prog[6] = w(0, 5); prog[7] = w(0, 4);
      start();
      go(8);
      peek(VEC[k][7:4], VEC[k][3:0], "R5 alu result");
      chk("R3 alu only on bus", bus_o, VEC[k][3:0]);
      chk("R2 pc", pc_o, 8);
    end

    // R3 immediate only while ROM open
    clear_prog();
    prog[0] = w(0, 6); prog[1] = w(6, 4); prog[2] = w(0, 6); prog[3] = w(9, 4);
    start();
    go(2);
    chk("R3 imm on bus", bus_o, 6);
    peek(4'd0, 6, "R3 imm written");
    go(2);
    chk("R3 closed bus", bus_o, 0);
    peek(4'd0, 0, "R3 closed imm ignored");

    // R4 contention: ROM and ALU both open
    clear_prog();
    prog[0] = w(0, 6); prog[1] = w(3, 1); prog[2] = w(0, 2); prog[3] = w(4, 5);
    prog[4] = w(8, 4);
    start();
    go(5);
    peek(4'd0, 11, "R4 OR of sources");
    chk("R4 conflict flag", conflict_o, 1);

    // R6 RAM source drives address register
    clear_prog();
    prog[0] = w(0, 6); prog[1] = w(3, 0); prog[2] = w(7, 4); prog[3] = w(0, 6);
    prog[4] = w(0, 7); prog[5] = w(0, 0); prog[6] = w(0, 7); prog[7] = w(0, 6);
    prog[8] = w(2, 4);
    start();
    go(9);
    peek(4'd3, 7, "R6 ram write at address");
    peek(4'd7, 2, "R6 address from ram");

    // R7 unconditional PC load
    clear_prog();
    prog[0] = w(0, 6); prog[1] = w(6, 3); prog[2] = w(1, 4); prog[6] = w(9, 4);
    start();
    go(3);
    peek(4'd0, 9, "R7 jump target");
    chk("R7 pc after jump", pc_o, 7);

    // R7 conditional taken
    clear_prog();
    prog[0] = w(0, 6); prog[1] = w(3, 1); prog[2] = w(3, 2); prog[3] = w(7, 9);
    prog[4] = w(5, 4); prog[7] = w(12, 4);
    start();
    go(5);
    peek(4'd0, 12, "R7 branch taken");
    chk("R7 taken pc", pc_o, 8);

    // R7 conditional not taken
    prog[2] = w(4, 2);
    start();
    go(5);
    peek(4'd0, 5, "R7 branch not taken");
    chk("R7 fallthrough pc", pc_o, 5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule